// File: doc/BRIEF.md
# Progressive-Programming Block Wear Tracker

This unit sits in a flash controller and holds per-block state for progressive single-level programming. Under this scheme, a block takes several full write passes between two erases. How many passes it may take depends on the block's wear.

For every block the unit keeps three values:
- the next page expected in the current pass;
- the number of complete passes done since the last erase;
- a lifetime erase counter.

From the erase counter and a scheme choice made at build time, it derives the pass budget per erase, written Kp. Two schemes are available. With level-shift programming the budget steps down from four passes. With fixed-level programming it steps down from three.

The caller presents one command per cycle: either a page write or an erase, aimed at one block. One cycle later the unit returns a verdict. For an accepted write it also returns the pass index and the erase count that must accompany the page data sent to the flash. It also reports whether the block now needs an erase. Writes that skip a page are refused, as are writes to a block whose budget is spent. A block that has exceeded its erase lifetime is retired, and every command to it is refused from then on.

Top module: `sc_block_tracker`

## Requirements
- R1: After reset `rsp_valid` is 0. Every block expects page 0, has pass count 0 and erase count 0, and has the largest Kp of its scheme.
- R2: A write to the page a block expects returns status OK (code 0). It also returns `rsp_wr_index` equal to the pass count before the write, and `rsp_erase_cnt` equal to the block's erase count.
- R3: A write naming any page other than the expected one returns status ORDER (code 1) and leaves the block's state unchanged.
- R4: Writing the last page (index PAGES-1) wraps the expected page to 0 and adds one to the pass count. The next write to page 0 then reports the incremented pass index.
- R5: When the pass count reaches Kp, the response carries `rsp_need_erase` = 1. Every later write to that block returns status FULL (code 3) until the block is erased.
- R6: An erase of a live block returns status OK, clears the expected page and the pass count (`rsp_wr_index` = 0), adds one to the erase count, and reports the Kp recomputed for the new count.
- R7: With SCHEME = 0 (level-shift), Kp is 4 for erase counts up to 3200, 3 up to 8500, 2 up to 24200, and 1 above that. Kp never rises across an erase.
- R8: With SCHEME = 1 (fixed-level), Kp is 3 for erase counts up to 6900, 2 up to 22500, and 1 above that.
- R9: An erase that takes the count above ERASE_LIMIT (100000) retires the block. Every later write or erase to it returns status RETIRED (code 2) and changes nothing.
- R10: Commands to one block leave every other block's state untouched.
- R11: Each response appears exactly one cycle after its command. `rsp_valid` is 0 in any cycle that follows a cycle without a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 1 | 0 = page write, 1 = erase |
| cmd_block | input | BLK_W | Target block |
| cmd_page | input | PAGE_W | Page index for writes |
| rsp_valid | output | 1 | Response present |
| rsp_status | output | 2 | 0 OK, 1 ORDER, 2 RETIRED, 3 FULL |
| rsp_wr_index | output | CNT_W | Pass index to send with the page data |
| rsp_erase_cnt | output | ERASE_W | Block erase count after the command |
| rsp_kp | output | CNT_W | Pass budget for the block after the command |
| rsp_need_erase | output | 1 | Block has spent its budget and is live |

## Verification
The assertions rely on three properties of the inputs. Commands carry a block number inside the configured range. The reset is held for at least one clock. Each command's response is read before the command it names could have been altered by a later one. The bench issues one command per task step on the falling edge and reads the registered response on the next falling edge. It only addresses blocks below NUM_BLOCKS, so every property sees legal, well-spaced commands. Wear is reached by issuing real erases rather than by preloading counters, so the erase counter never jumps.

// File: rtl/sc_tracker_pkg.sv
package sc_tracker_pkg;
   typedef enum logic [1:0] {
      ST_OK      = 2'd0,
      ST_ORDER   = 2'd1,
      ST_RETIRED = 2'd2,
      ST_FULL    = 2'd3
   } sc_status_e;

   localparam logic OP_WRITE = 1'b0;
   localparam logic OP_ERASE = 1'b1;

   localparam int SCHEME_SHIFT = 0;
   localparam int SCHEME_FIXED = 1;
endpackage

// File: rtl/sc_kp_lookup.sv
module sc_kp_lookup #(
   parameter int SCHEME  = 0,
   parameter int ERASE_W = 17,
   parameter int CNT_W   = 3
) (
   input  logic [ERASE_W-1:0] erase_cnt,
   output logic [CNT_W-1:0]   kp
);
   import sc_tracker_pkg::*;

   generate
      if (SCHEME == SCHEME_SHIFT) begin : g_shift
         localparam logic [ERASE_W-1:0] T1 = ERASE_W'(3200);
         localparam logic [ERASE_W-1:0] T2 = ERASE_W'(8500);
         localparam logic [ERASE_W-1:0] T3 = ERASE_W'(24200);
         always_comb begin
            if (erase_cnt <= T1)      kp = CNT_W'(4);
            else if (erase_cnt <= T2) kp = CNT_W'(3);
            else if (erase_cnt <= T3) kp = CNT_W'(2);
            else                      kp = CNT_W'(1);
         end
      end else if (SCHEME == SCHEME_FIXED) begin : g_fixed
         localparam logic [ERASE_W-1:0] T1 = ERASE_W'(6900);
         localparam logic [ERASE_W-1:0] T2 = ERASE_W'(22500);
         always_comb begin
            if (erase_cnt <= T1)      kp = CNT_W'(3);
            else if (erase_cnt <= T2) kp = CNT_W'(2);
            else                      kp = CNT_W'(1);
         end
      end else begin : g_bad
         $error("sc_kp_lookup: unknown SCHEME");
         assign kp = CNT_W'(1);
      end
   endgenerate
endmodule

// File: rtl/sc_block_store.sv
module sc_block_store #(
   parameter int NUM_BLOCKS = 16,
   parameter int BLK_W      = 4,
   parameter int PAGE_W     = 7,
   parameter int CNT_W      = 3,
   parameter int ERASE_W    = 17
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [BLK_W-1:0]   rd_blk,
   output logic [PAGE_W-1:0]  rd_page,
   output logic [CNT_W-1:0]   rd_count,
   output logic [ERASE_W-1:0] rd_erase,
   output logic               rd_retired,
   input  logic               wr_en,
   input  logic [BLK_W-1:0]   wr_blk,
   input  logic [PAGE_W-1:0]  wr_page,
   input  logic [CNT_W-1:0]   wr_count,
   input  logic [ERASE_W-1:0] wr_erase,
   input  logic               wr_retired
);
   logic [PAGE_W-1:0]  page_q    [NUM_BLOCKS];
   logic [CNT_W-1:0]   count_q   [NUM_BLOCKS];
   logic [ERASE_W-1:0] erase_q   [NUM_BLOCKS];
   logic               retired_q [NUM_BLOCKS];

   generate
      for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               page_q[b]    <= '0;
               count_q[b]   <= '0;
               erase_q[b]   <= '0;
               retired_q[b] <= 1'b0;
            end else if (wr_en && (wr_blk == BLK_W'(b))) begin
               page_q[b]    <= wr_page;
               count_q[b]   <= wr_count;
               erase_q[b]   <= wr_erase;
               retired_q[b] <= wr_retired;
            end
         end
      end
   endgenerate

   assign rd_page    = page_q[rd_blk];
   assign rd_count   = count_q[rd_blk];
   assign rd_erase   = erase_q[rd_blk];
   assign rd_retired = retired_q[rd_blk];
endmodule

// File: rtl/sc_cmd_decide.sv
module sc_cmd_decide #(
   parameter int PAGES       = 128,
   parameter int PAGE_W      = 7,
   parameter int CNT_W       = 3,
   parameter int ERASE_W     = 17,
   parameter int ERASE_LIMIT = 100000
) (
   input  logic               op,
   input  logic [PAGE_W-1:0]  page,
   input  logic [PAGE_W-1:0]  cur_page,
   input  logic [CNT_W-1:0]   cur_count,
   input  logic [ERASE_W-1:0] cur_erase,
   input  logic               cur_retired,
   input  logic [CNT_W-1:0]   kp_cur,
   output logic [1:0]         status,
   output logic               upd_en,
   output logic [PAGE_W-1:0]  nx_page,
   output logic [CNT_W-1:0]   nx_count,
   output logic [ERASE_W-1:0] nx_erase,
   output logic               nx_retired,
   output logic [CNT_W-1:0]   wr_index
);
   import sc_tracker_pkg::*;

   localparam logic [PAGE_W-1:0]  LAST_PAGE = PAGE_W'(PAGES - 1);
   localparam logic [ERASE_W-1:0] LIMIT_V   = ERASE_W'(ERASE_LIMIT);

   logic [ERASE_W-1:0] erase_inc;
   assign erase_inc = cur_erase + ERASE_W'(1);

   always_comb begin
      status     = ST_OK;
      upd_en     = 1'b0;
      nx_page    = cur_page;
      nx_count   = cur_count;
      nx_erase   = cur_erase;
      nx_retired = cur_retired;
      wr_index   = cur_count;
      if (cur_retired) begin
         status = ST_RETIRED;
      end else if (op == OP_ERASE) begin
         upd_en     = 1'b1;
         nx_page    = '0;
         nx_count   = '0;
         nx_erase   = erase_inc;
         nx_retired = (erase_inc > LIMIT_V);
         wr_index   = '0;
      end else if (cur_count >= kp_cur) begin
         status = ST_FULL;
      end else if (page != cur_page) begin
         status = ST_ORDER;
      end else begin
         upd_en = 1'b1;
         if (page == LAST_PAGE) begin
            nx_page  = '0;
            nx_count = cur_count + CNT_W'(1);
         end else begin
            nx_page  = cur_page + PAGE_W'(1);
         end
      end
   end
endmodule

// File: rtl/sc_block_tracker.sv
module sc_block_tracker #(
   parameter int NUM_BLOCKS  = 16,
   parameter int PAGES       = 128,
   parameter int SCHEME      = 0,
   parameter int ERASE_LIMIT = 100000,
   parameter int CNT_W       = 3,
   parameter int BLK_W       = $clog2(NUM_BLOCKS),
   parameter int PAGE_W      = $clog2(PAGES),
   parameter int ERASE_W     = $clog2(ERASE_LIMIT + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic               cmd_op,
   input  logic [BLK_W-1:0]   cmd_block,
   input  logic [PAGE_W-1:0]  cmd_page,
   output logic               rsp_valid,
   output logic [1:0]         rsp_status,
   output logic [CNT_W-1:0]   rsp_wr_index,
   output logic [ERASE_W-1:0] rsp_erase_cnt,
   output logic [CNT_W-1:0]   rsp_kp,
   output logic               rsp_need_erase
);
   import sc_tracker_pkg::*;

   localparam int KP_MAX = (SCHEME == SCHEME_SHIFT) ? 4 : 3;

   generate
      if (NUM_BLOCKS != (1 << BLK_W)) begin : g_chk_blk
         $error("NUM_BLOCKS must be a power of two");
      end
      if (PAGES != (1 << PAGE_W)) begin : g_chk_pg
         $error("PAGES must be a power of two");
      end
      if (KP_MAX >= (1 << CNT_W)) begin : g_chk_cnt
         $error("CNT_W too narrow for pass budget");
      end
   endgenerate

   logic [PAGE_W-1:0]  rd_page, nx_page;
   logic [CNT_W-1:0]   rd_count, nx_count, kp_cur, kp_new, wr_index;
   logic [ERASE_W-1:0] rd_erase, nx_erase;
   logic               rd_retired, nx_retired, upd_en;
   logic [1:0]         status;

   sc_block_store #(
      .NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W), .PAGE_W(PAGE_W),
      .CNT_W(CNT_W), .ERASE_W(ERASE_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .rd_blk(cmd_block), .rd_page(rd_page), .rd_count(rd_count),
      .rd_erase(rd_erase), .rd_retired(rd_retired),
      .wr_en(upd_en && cmd_valid), .wr_blk(cmd_block), .wr_page(nx_page),
      .wr_count(nx_count), .wr_erase(nx_erase), .wr_retired(nx_retired)
   );

   sc_kp_lookup #(.SCHEME(SCHEME), .ERASE_W(ERASE_W), .CNT_W(CNT_W))
      u_kp_cur (.erase_cnt(rd_erase), .kp(kp_cur));

   sc_kp_lookup #(.SCHEME(SCHEME), .ERASE_W(ERASE_W), .CNT_W(CNT_W))
      u_kp_new (.erase_cnt(nx_erase), .kp(kp_new));

   sc_cmd_decide #(
      .PAGES(PAGES), .PAGE_W(PAGE_W), .CNT_W(CNT_W),
      .ERASE_W(ERASE_W), .ERASE_LIMIT(ERASE_LIMIT)
   ) u_decide (
      .op(cmd_op), .page(cmd_page),
      .cur_page(rd_page), .cur_count(rd_count), .cur_erase(rd_erase),
      .cur_retired(rd_retired), .kp_cur(kp_cur),
      .status(status), .upd_en(upd_en),
      .nx_page(nx_page), .nx_count(nx_count), .nx_erase(nx_erase),
      .nx_retired(nx_retired), .wr_index(wr_index)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid      <= 1'b0;
         rsp_status     <= '0;
         rsp_wr_index   <= '0;
         rsp_erase_cnt  <= '0;
         rsp_kp         <= CNT_W'(KP_MAX);
         rsp_need_erase <= 1'b0;
      end else begin
         rsp_valid <= cmd_valid;
         if (cmd_valid) begin
            rsp_status     <= status;
            rsp_wr_index   <= wr_index;
            rsp_erase_cnt  <= nx_erase;
            rsp_kp         <= kp_new;
            rsp_need_erase <= (nx_count >= kp_new) && !nx_retired;
         end
      end
   end

   // R11: one response per command, one cycle later
   assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> rsp_valid);
   assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !rsp_valid);
   // R5: stored pass count never exceeds the live budget
   assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> rd_count <= kp_cur);
   // R9: retired blocks refuse everything
   assert_retired_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && rd_retired |=> rsp_status == ST_RETIRED);
   // R7: budget does not grow across an erase
   assert_kp_nonincreasing_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == OP_ERASE && !rd_retired |=> rsp_kp <= $past(kp_cur));
   // R6: an accepted erase restarts the pass index
   assert_erase_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == OP_ERASE && !rd_retired |=>
      rsp_status == ST_OK && rsp_wr_index == '0);
endmodule

// File: tb/test_sc_block_tracker.sv
module test_sc_block_tracker;
   localparam int BLK_W = 4, PAGE_W = 7, CNT_W = 3, ERASE_W = 17;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0, cmd_op = 1'b0;
   logic [BLK_W-1:0] cmd_block = '0;
   logic [PAGE_W-1:0] cmd_page = '0;
   logic rsp_valid, rsp_need_erase, rsp_valid_fp, rsp_need_erase_fp;
   logic [1:0] rsp_status, rsp_status_fp;
   logic [CNT_W-1:0] rsp_wr_index, rsp_kp, rsp_wr_index_fp, rsp_kp_fp;
   logic [ERASE_W-1:0] rsp_erase_cnt, rsp_erase_cnt_fp;

   int n_checks = 0, n_fail = 0;

   always #4 clk = ~clk;

   sc_block_tracker #(.SCHEME(0)) i_sc_block_tracker (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_block(cmd_block), .cmd_page(cmd_page), .rsp_valid(rsp_valid),
      .rsp_status(rsp_status), .rsp_wr_index(rsp_wr_index),
      .rsp_erase_cnt(rsp_erase_cnt), .rsp_kp(rsp_kp),
      .rsp_need_erase(rsp_need_erase));

   sc_block_tracker #(.SCHEME(1)) i_sc_block_tracker_fp (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_block(cmd_block), .cmd_page(cmd_page), .rsp_valid(rsp_valid_fp),
      .rsp_status(rsp_status_fp), .rsp_wr_index(rsp_wr_index_fp),
      .rsp_erase_cnt(rsp_erase_cnt_fp), .rsp_kp(rsp_kp_fp),
      .rsp_need_erase(rsp_need_erase_fp));

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_cmd(input logic op, input int blk, input int page);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_block = BLK_W'(blk);
      cmd_page  = PAGE_W'(page);
      @(negedge clk);
   endtask

   task automatic idle();
      cmd_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1", "rsp_valid after reset", int'(rsp_valid), 0);
      check("R1", "reset kp", int'(rsp_kp), 4);
      do_cmd(1'b0, 0, 0);
      check("R2", "first write status", int'(rsp_status), 0);
      check("R2", "first write index", int'(rsp_wr_index), 0);
      check("R2", "first write erase count", int'(rsp_erase_cnt), 0);
      check("R1", "fixed-level reset kp", int'(rsp_kp_fp), 3);
      check("R11", "rsp_valid with command", int'(rsp_valid), 1);
      idle();
      check("R11", "rsp_valid idle", int'(rsp_valid), 0);
   endtask

   task automatic t_order();
      do_cmd(1'b0, 1, 5);
      check("R3", "skipped page status", int'(rsp_status), 1);
      do_cmd(1'b0, 1, 0);
      check("R3", "state unchanged after refusal", int'(rsp_status), 0);
   endtask

   task automatic t_wrap();
      int bad = 0;
      for (int p = 1; p < 128; p++) begin
         do_cmd(1'b0, 0, p);
         if (rsp_status != 2'd0 || rsp_wr_index != 0) bad++;
      end
      check("R2", "sequential pass 0 writes refused", bad, 0);
      do_cmd(1'b0, 0, 0);
      check("R4", "wrap status", int'(rsp_status), 0);
      check("R4", "pass index after wrap", int'(rsp_wr_index), 1);
   endtask

   task automatic t_full();
      int bad = 0;
      for (int p = 1; p < 128; p++) begin
         do_cmd(1'b0, 0, p);
         if (rsp_status != 2'd0) bad++;
      end
      for (int pass = 2; pass < 4; pass++) begin
         for (int p = 0; p < 128; p++) begin
            do_cmd(1'b0, 0, p);
            if (rsp_status != 2'd0 || rsp_wr_index != CNT_W'(pass)) bad++;
            if (!(pass == 3 && p == 127) && rsp_need_erase) bad++;
         end
      end
      check("R4", "passes 1..3 writes", bad, 0);
      check("R5", "need_erase at budget", int'(rsp_need_erase), 1);
      do_cmd(1'b0, 0, 0);
      check("R5", "write past budget status", int'(rsp_status), 3);
   endtask

   task automatic t_indep();
      do_cmd(1'b0, 1, 1);
      check("R10", "other block continues", int'(rsp_status), 0);
      check("R10", "other block pass index", int'(rsp_wr_index), 0);
      check("R10", "other block erase count", int'(rsp_erase_cnt), 0);
   endtask

   task automatic t_erase();
      do_cmd(1'b1, 0, 0);
      check("R6", "erase status", int'(rsp_status), 0);
      check("R6", "erase count", int'(rsp_erase_cnt), 1);
      check("R6", "kp after erase", int'(rsp_kp), 4);
      check("R6", "need_erase cleared", int'(rsp_need_erase), 0);
      do_cmd(1'b0, 0, 0);
      check("R6", "page 0 after erase", int'(rsp_status), 0);
      check("R6", "pass index after erase", int'(rsp_wr_index), 0);
   endtask

   task automatic t_wear();
      for (int i = 1; i <= 100000; i++) begin
         do_cmd(1'b1, 2, 0);
         case (i)
            3200:  check("R7", "kp at 3200", int'(rsp_kp), 4);
            3201:  check("R7", "kp at 3201", int'(rsp_kp), 3);
            6900:  check("R8", "fixed kp at 6900", int'(rsp_kp_fp), 3);
            6901:  check("R8", "fixed kp at 6901", int'(rsp_kp_fp), 2);
            8500:  check("R7", "kp at 8500", int'(rsp_kp), 3);
            8501:  check("R7", "kp at 8501", int'(rsp_kp), 2);
            22500: check("R8", "fixed kp at 22500", int'(rsp_kp_fp), 2);
            22501: check("R8", "fixed kp at 22501", int'(rsp_kp_fp), 1);
            24200: check("R7", "kp at 24200", int'(rsp_kp), 2);
            24201: check("R7", "kp at 24201", int'(rsp_kp), 1);
            default: ;
         endcase
      end
      check("R6", "erase count 100000", int'(rsp_erase_cnt), 100000);
      do_cmd(1'b0, 2, 0);
      check("R9", "write at limit accepted", int'(rsp_status), 0);
      do_cmd(1'b1, 2, 0);
      check("R9", "retiring erase status", int'(rsp_status), 0);
      check("R9", "retiring erase count", int'(rsp_erase_cnt), 100001);
      do_cmd(1'b0, 2, 0);
      check("R9", "write to retired", int'(rsp_status), 2);
      do_cmd(1'b1, 2, 0);
      check("R9", "erase to retired", int'(rsp_status), 2);
      check("R9", "retired count frozen", int'(rsp_erase_cnt), 100001);
      do_cmd(1'b0, 1, 2);
      check("R10", "neighbour unaffected by retire", int'(rsp_status), 0);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_order();
      t_wrap();
      t_full();
      t_indep();
      t_erase();
      t_wear();
      idle();
      finish_run();
   end
endmodule